// File: doc/BRIEF.md
# Parallel Port Extended-Mode Controller

This block is the host-side register slice of a PC-style parallel port that owns the extended control register, the three-bit personality (mode) field inside it, and a byte-wide transmit FIFO. A host reaches it over a byte-wide register bus with separate read and write strobes and an address offset from the port base. The extended control register lives at offset 0x402. Offset 0x400 is shared: it is the FIFO data port for writes in the FIFO-class modes, and it returns configuration register A on reads in configuration mode.

The mode field decides what the FIFO does. Some modes accept bytes, some also drain them, and the two non-FIFO modes (standard and bidirectional) keep it empty. A direct hop between two modes numbered 2 or higher is refused. Software must step through the bidirectional mode, and that step flushes the FIFO. A pacing counter models the peripheral: in the two drain modes, one byte leaves the FIFO every `DRAIN_DIV` clocks into a one-byte output holding stage. That stage is a valid/ready stream. A byte that sits there is outside the FIFO, and configuration register A reports it so that software can count the residue correctly.

Back-pressure rules for the output stream are as follows. `tx_valid` rises only when a byte is loaded into the holding stage. `tx_valid` and `tx_data` then stay unchanged until a cycle in which `tx_ready` is high, and the byte is consumed in that cycle. While the holding stage is full, no further byte leaves the FIFO. `tx_ready` never affects anything other than the holding stage.

Top module: `pp_ext_ctrl`

## Requirements
- R1: After reset the extended control register reads 0x25, meaning mode 001, stored bits 4:2 = 001 and the FIFO empty. Also after reset, `tx_valid` is 0, `mode_err` is 0 and `port_mode` is 001.
- R2: The extended control register layout at offset 0x402 is as follows. Bits 7:5 are the mode. Bits 4:2 are plain stored bits. Bit 1 is FIFO full and bit 0 is FIFO empty. Bits 1:0 are read-only, and writes to them are ignored.
- R3: A bus write to offset 0x400 enqueues its byte only in mode 010, 011 or 110. In every other mode the byte is discarded and the FIFO stays unchanged.
- R4: When the FIFO holds `FIFO_DEPTH` bytes, bit 1 reads 1, and a further write to offset 0x400 is dropped without changing the contents.
- R5: A write to the extended control register whose new mode and current mode are both 2 or higher and differ is rejected. Mode and bits 4:2 keep their old values, and `mode_err` is set and stays set until reset. Rewriting the current mode is legal.
- R6: An accepted write of mode 000 or 001 empties the FIFO, and bit 0 reads 1 from the next cycle on.
- R7: In modes 010 and 011, one byte moves from the FIFO head into the output holding stage on every `DRAIN_DIV`-th clock spent in that mode, provided the stage is empty. Bytes leave in the order they were written.
- R8: `tx_valid` holds with `tx_data` stable until `tx_ready` is high. No byte is loaded into the holding stage in any mode other than 010 or 011.
- R9: In mode 111 a read of offset 0x400 returns configuration register A. Its value is 0x14 when the holding stage is empty and 0x10 when it holds a byte (bit 2 = 1 means no byte outside the FIFO). In other modes that read returns 0x00.
- R10: `bus_rdata` is 0x00 when `bus_rd` is low and for any offset other than 0x400 and 0x402.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register offset from the port base |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from current state |
| tx_valid | output | 1 | Holding stage has a byte for the peripheral |
| tx_ready | input | 1 | Peripheral takes the held byte this cycle |
| tx_data | output | 8 | Held byte |
| port_mode | output | 3 | Current mode field |
| mode_err | output | 1 | Sticky flag: an illegal direct mode change was attempted |

## Verification
The bench tries a direct hop from test mode to FIFO mode while the FIFO is full. A design that let that hop through would show the new mode and keep stale bytes, and one that flushed on it would read empty. The bench overfills the FIFO in a mode that does not drain. A design with an off-by-one full test would either show full one byte early or wrap its pointers and corrupt the head. The bench keeps a byte parked in the holding stage across a flush and a move to configuration mode. A design that counted that byte as part of the FIFO, or cleared it on flush, would return the wrong value for configuration register A. Finally, the bench drains with an irregular `tx_ready` pattern and compares the received order and the exact cycle of each load. A pacer that restarts wrongly or a stage that drops a byte under back-pressure shows up as a data mismatch.

// File: rtl/pp_ext_pkg.sv
package pp_ext_pkg;

  typedef enum logic [2:0] {
    MODE_STD   = 3'b000,
    MODE_BIDIR = 3'b001,
    MODE_FIFO  = 3'b010,
    MODE_ECP   = 3'b011,
    MODE_EPP   = 3'b100,
    MODE_VND   = 3'b101,
    MODE_TEST  = 3'b110,
    MODE_CFG   = 3'b111
  } pp_mode_e;

  // Modes whose FIFO data port takes bytes from the host.
  function automatic logic mode_takes_bytes(input logic [2:0] m);
    return (m == MODE_FIFO) || (m == MODE_ECP) || (m == MODE_TEST);
  endfunction

  // Modes in which the modelled peripheral consumes bytes.
  function automatic logic mode_drains(input logic [2:0] m);
    return (m == MODE_FIFO) || (m == MODE_ECP);
  endfunction

  // Modes 2..7 belong to the FIFO-gated class.
  function automatic logic mode_is_upper(input logic [2:0] m);
    return m[2] | m[1];
  endfunction

endpackage

// File: rtl/pp_byte_fifo.sv
module pp_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

endmodule

// File: rtl/pp_ecr_ctl.sv
module pp_ecr_ctl
  import pp_ext_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [2:0] mode,
  output logic [2:0] aux,
  output logic       flush,
  output logic       err
);

  logic [2:0] req_mode;
  logic       legal;

  assign req_mode = wdata[7:5];
  // Hopping straight between two upper modes is forbidden.
  assign legal = !(mode_is_upper(mode) && mode_is_upper(req_mode) && (req_mode != mode));
  assign flush = wr && legal && !mode_is_upper(req_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MODE_BIDIR;
      aux  <= 3'b001;
      err  <= 1'b0;
    end else if (wr) begin
      if (legal) begin
        mode <= req_mode;
        aux  <= wdata[4:2];
      end else begin
        err  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pp_drain_pacer.sv
module pp_drain_pacer #(
  parameter int DIV   = 8,
  localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pp_ext_ctrl.sv
module pp_ext_ctrl
  import pp_ext_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DRAIN_DIV  = 8,
  parameter int ADDR_W     = 11,
  parameter logic [ADDR_W-1:0] OFS_FIFO = ADDR_W'('h400),
  parameter logic [ADDR_W-1:0] OFS_ECR  = ADDR_W'('h402)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic [2:0]        port_mode,
  output logic              mode_err
);

  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [7:0] CFGA_ID = 8'h10;

  logic          ecr_wr, fifo_wr, flush, tick;
  logic          f_empty, f_full, f_pop;
  logic [CW-1:0] f_count;
  logic [7:0]    f_dout;
  logic [2:0]    mode, aux;
  logic          hold_v;
  logic [7:0]    hold_d;

  assign ecr_wr  = bus_wr && (bus_addr == OFS_ECR);
  assign fifo_wr = bus_wr && (bus_addr == OFS_FIFO) && mode_takes_bytes(mode);

  pp_ecr_ctl u_ecr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ecr_wr),
    .wdata (bus_wdata),
    .mode  (mode),
    .aux   (aux),
    .flush (flush),
    .err   (mode_err)
  );

  pp_drain_pacer #(.DIV(DRAIN_DIV)) u_pace (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (mode_drains(mode)),
    .tick  (tick)
  );

  assign f_pop = tick && !f_empty && !hold_v && !flush;

  pp_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (fifo_wr),
    .din   (bus_wdata),
    .pop   (f_pop),
    .dout  (f_dout),
    .empty (f_empty),
    .full  (f_full),
    .count (f_count)
  );

  // One-byte holding stage toward the peripheral.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (f_pop) begin
      hold_v <= 1'b1;
      hold_d <= f_dout;
    end else if (hold_v && tx_ready) begin
      hold_v <= 1'b0;
    end
  end

  assign tx_valid  = hold_v;
  assign tx_data   = hold_d;
  assign port_mode = mode;

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      if (bus_addr == OFS_ECR)
        bus_rdata = {mode, aux, f_full, f_empty};
      else if (bus_addr == OFS_FIFO && mode == MODE_CFG)
        bus_rdata = CFGA_ID | {5'b0, !hold_v, 2'b00};
    end
  end

endmodule

// File: rtl/pp_ext_ctrl_chk.sv
module pp_ext_ctrl_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ecr_wr,
  input logic [2:0]    req_mode,
  input logic [2:0]    mode,
  input logic [2:0]    aux,
  input logic          err,
  input logic          f_empty,
  input logic          f_full,
  input logic [CW-1:0] f_count,
  input logic          fifo_wr,
  input logic          f_pop,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data
);

  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_empty && f_full)); // R2

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (f_full && fifo_wr && !f_pop && !ecr_wr) |=> (f_count == $past(f_count)) && f_full); // R4

  AST_ILLEGAL_HOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ecr_wr && (mode >= 3'd2) && (req_mode >= 3'd2) && (req_mode != mode))
      |=> (mode == $past(mode)) && (aux == $past(aux)) && err); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R5

  AST_LOW_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ecr_wr && (req_mode < 3'd2)) |=> f_empty); // R6

  AST_NO_LOAD_OUTSIDE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && (mode != 3'd2) && (mode != 3'd3)) |=> !tx_valid); // R8

  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data)); // R8

endmodule

bind pp_ext_ctrl pp_ext_ctrl_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ecr_wr   (ecr_wr),
  .req_mode (bus_wdata[7:5]),
  .mode     (port_mode),
  .aux      (aux),
  .err      (mode_err),
  .f_empty  (f_empty),
  .f_full   (f_full),
  .f_count  (f_count),
  .fifo_wr  (fifo_wr),
  .f_pop    (f_pop),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data)
);

// File: tb/pp_ext_ctrl_test.sv
module pp_ext_ctrl_test;

  localparam int DEPTH = 16;
  localparam int DIV   = 8;
  localparam logic [10:0] A_FIFO = 11'h400;
  localparam logic [10:0] A_ECR  = 11'h402;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, tx_ready = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata, tx_data;
  logic        tx_valid, mode_err;
  logic [2:0]  port_mode;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pp_ext_ctrl #(.FIFO_DEPTH(DEPTH), .DRAIN_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .port_mode(port_mode), .mode_err(mode_err)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] q[$];
  logic [7:0] got[$];
  logic [7:0] sent[$];
  int         m_mode, m_aux, m_cnt;
  logic       m_err, m_hv;
  logic [7:0] m_hd;
  logic       e_w, f_w, legal, fl, tk, old_hv;
  int         nm, pre;

  function automatic logic upper(input int m);
    return m >= 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_mode = 1; m_aux = 1; m_cnt = 0; m_err = 0; m_hv = 0; m_hd = 0;
    end else begin
      if (tx_valid && tx_ready) got.push_back(tx_data);
      e_w   = bus_wr && bus_addr == A_ECR;
      f_w   = bus_wr && bus_addr == A_FIFO;
      nm    = int'(bus_wdata[7:5]);
      legal = !(upper(m_mode) && upper(nm) && nm != m_mode);
      fl    = e_w && legal && nm < 2;
      tk    = 0;
      if (m_mode == 2 || m_mode == 3) begin
        if (m_cnt == DIV - 1) begin tk = 1; m_cnt = 0; end
        else m_cnt++;
      end else m_cnt = 0;
      old_hv = m_hv;
      pre    = q.size();
      if (m_hv && tx_ready) m_hv = 0;
      if (tk && pre > 0 && !old_hv && !fl) begin
        m_hd = q.pop_front();
        m_hv = 1;
      end
      if (f_w && (m_mode == 2 || m_mode == 3 || m_mode == 6) && pre < DEPTH)
        q.push_back(bus_wdata);
      if (fl) q.delete();
      if (e_w) begin
        if (legal) begin m_mode = nm; m_aux = int'(bus_wdata[4:2]); end
        else m_err = 1;
      end
    end
  end

  function automatic logic [7:0] model_read(input logic [10:0] a);
    if (a == A_ECR)
      return {m_mode[2:0], m_aux[2:0], q.size() == DEPTH, q.size() == 0};
    if (a == A_FIFO && m_mode == 7)
      return m_hv ? 8'h10 : 8'h14;
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison after the edge has settled.
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R8 tx_valid", {7'b0, tx_valid}, {7'b0, m_hv});
      if (m_hv) chk("R7 tx_data order", tx_data, m_hd);
      chk("R5 mode_err", {7'b0, mode_err}, {7'b0, m_err});
      chk("R5 port_mode", {5'b0, port_mode}, 8'(m_mode));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, input string tag, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    v = bus_rdata;
    chk(tag, v, model_read(a));
    #1 bus_rd = 1'b0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset value
    rd(A_ECR, "R1 reset ECR model", v);
    chk("R1 reset ECR", v, 8'h25);
    chk("R1 reset mode", {5'b0, port_mode}, 8'h01);

    // R3: FIFO write ignored in bidirectional mode
    wr(A_FIFO, 8'hA5);
    rd(A_ECR, "R3 write ignored", v);
    chk("R3 still empty", v, 8'h25);

    // R2: stored bits written, status bits read-only
    wr(A_ECR, 8'h3F);
    rd(A_ECR, "R2 layout", v);
    chk("R2 layout const", v, 8'h3D);

    // R4: fill in test mode (no drain), then overflow
    wr(A_ECR, 8'hC0);
    for (int i = 0; i < DEPTH + 2; i++) wr(A_FIFO, 8'(i));
    rd(A_ECR, "R4 full flag", v);
    chk("R4 full const", v, 8'hC2);
    repeat (40) @(negedge clk);
    chk("R8 no load in test mode", {7'b0, tx_valid}, 8'h00);

    // R5: illegal direct hop test -> FIFO mode
    wr(A_ECR, 8'h5C);
    rd(A_ECR, "R5 hop rejected", v);
    chk("R5 hop rejected const", v, 8'hC2);
    chk("R5 err set", {7'b0, mode_err}, 8'h01);
    wr(A_ECR, 8'hC4);
    rd(A_ECR, "R5 same mode rewrite legal", v);

    // R6: stepping to bidirectional flushes
    wr(A_ECR, 8'h20);
    rd(A_ECR, "R6 flush", v);
    chk("R6 flush const", v, 8'h21);

    // R7/R9: ECP-class mode with back-pressure, byte parked in stage
    wr(A_ECR, 8'h60);
    for (int i = 0; i < 20; i++) wr(A_FIFO, 8'h80 + 8'(i));
    rd(A_ECR, "R4 full with parked byte", v);
    rd(A_FIFO, "R9 cfgA hidden outside cfg mode", v);
    chk("R9 cfgA hidden const", v, 8'h00);
    wr(A_ECR, 8'h20);
    wr(A_ECR, 8'hE0);
    rd(A_FIFO, "R9 cfgA byte held", v);
    chk("R9 cfgA held const", v, 8'h10);
    @(negedge clk) tx_ready = 1'b1;
    @(negedge clk) tx_ready = 1'b0;
    rd(A_FIFO, "R9 cfgA stage empty", v);
    chk("R9 cfgA empty const", v, 8'h14);

    // R7: ordered drain under irregular ready
    wr(A_ECR, 8'h20);
    wr(A_ECR, 8'h40);
    got.delete(); sent.delete();
    for (int i = 0; i < 12; i++) begin
      sent.push_back(8'h30 + 8'(i));
      wr(A_FIFO, 8'h30 + 8'(i));
    end
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      tx_ready = (i % 3) != 0;
    end
    tx_ready = 1'b0;
    chk("R7 byte count", 8'(got.size()), 8'(sent.size()));
    for (int i = 0; i < sent.size() && i < got.size(); i++)
      chk("R7 drain order", got[i], sent[i]);

    // R10: undecoded offset and no strobe
    rd(11'h123, "R10 undecoded", v);
    chk("R10 undecoded const", v, 8'h00);
    @(negedge clk);
    bus_addr = A_ECR; bus_rd = 1'b0;
    #1 chk("R10 no strobe", bus_rdata, 8'h00);

    repeat (4) @(negedge clk);
    report();
    $finish;
  end

endmodule